// File: doc/BRIEF.md
# Per-Pin Debounce Filter with Power-of-Two Period

This block cleans up one general-purpose input before it reaches the input-status logic and the edge detector. It watches an already synchronized pin level and lets a change through only after the new level has held for a whole filter period. The period is a power of two in milliseconds, set by a 3-bit exponent in the pin's control word, so one field covers the range from 1 ms to 128 ms.

Time is measured in pulses of a free-running 1 ms tick that is generated somewhere else. A separate enable bit in the control word turns the filter on. When the filter is off, the raw level goes straight to the output in the same cycle. While it is off, the internal filtered state keeps tracking the pin, so turning the filter on causes no spurious edge.

Top module: `gpio_dbnc_filter`

## Requirements
- R1: Bit 8 of `ctrl_word` is the filter enable and bits 7:5 hold the period exponent n. No other bit of `ctrl_word` has any effect on `level_out`.
- R2: While the enable bit is 0, `level_out` equals `raw_in` in the same cycle.
- R3: While the filter is enabled and `raw_in` differs from `level_out`, `level_out` takes the `raw_in` value at the clock edge that samples the 2^n-th tick pulse after the mismatch began, and not before that edge.
- R4: If `raw_in` returns to the current `level_out` value for any sampled cycle before the period ends, the tick count restarts from zero.
- R5: Clock cycles without a tick pulse do not advance the count, however many of them there are.
- R6: Synchronous active-low reset loads the filtered level with the value `raw_in` has during reset.
- R7: The longest exponent, n = 7, needs exactly 128 tick pulses before the output changes.
- R8: Turning the enable on while `raw_in` is steady leaves `level_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse, once per millisecond |
| ctrl_word | input | 32 | Pin control word; enable at bit 8, exponent at bits 7:5 |
| raw_in | input | 1 | Synchronized raw pin level |
| level_out | output | 1 | Filtered pin level |

## Verification
The bench uses the default build: a 32-bit control word with a 3-bit exponent. This keeps the longest period at 128 ticks, so the bench can sweep all eight exponents in both edge directions. For each exponent it checks the output one tick before the expected change and again at the change. Idle cycles are placed between the ticks, which covers R5 throughout the sweep. Directed cases add a glitch in the middle of a count, control words with every unrelated bit set, pass-through while disabled, and reset with either pin level.

// File: rtl/gpio_dbnc_pkg.sv
// Package: shared constants for the debounce filter.
// Assumes: the control word layout is fixed for the whole pin block.
package gpio_dbnc_pkg;
    localparam int unsigned CTRL_W_DEF   = 32; // control word width
    localparam int unsigned EN_POS_DEF   = 8;  // filter enable bit position
    localparam int unsigned RATE_LSB_DEF = 5;  // exponent field low bit
    localparam int unsigned RATE_W_DEF   = 3;  // exponent field width
endpackage

// File: rtl/gpio_dbnc_decode.sv
// Module: gpio_dbnc_decode
// Pulls the enable bit and the exponent out of the control word and turns
// the exponent into a terminal count, 2^n - 1 ticks.
// Assumes: CNT_W >= 2**RATE_W, so the terminal count always fits.
module gpio_dbnc_decode #(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned EN_POS   = 8,
    parameter int unsigned RATE_LSB = 5,
    parameter int unsigned RATE_W   = 3,
    parameter int unsigned CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              filt_en,
    output logic [CNT_W-1:0]  last_cnt
);
    logic [RATE_W-1:0] rate;

    // Field extraction and terminal count computation
    always_comb begin
        filt_en  = ctrl_word[EN_POS];
        rate     = ctrl_word[RATE_LSB +: RATE_W];
        last_cnt = (CNT_W'(1) << rate) - CNT_W'(1);
    end

    // R3: the terminal count is always one less than a power of two
    assert_pow2_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((last_cnt & (last_cnt + CNT_W'(1))) == '0));
endmodule

// File: rtl/gpio_dbnc_counter.sv
// Module: gpio_dbnc_counter
// Counts tick pulses while the raw level differs from the filtered level.
// Raises done on the tick that completes the period.
// Assumes: tick is a one-cycle pulse. A lowered period takes effect at once,
// because the comparison uses >=.
module gpio_dbnc_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mismatch,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // Terminal detect and completion strobe
    always_comb begin
        at_end = (cnt_q >= last_cnt);
        done   = mismatch && tick && at_end;
    end

    // Tick counter: cleared on agreement, advanced only on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!mismatch) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R4: a cycle without mismatch leaves the count at zero
    assert_restart_on_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mismatch |=> (cnt_q == '0));

    // R5: without a tick the count never moves except to clear
    assert_no_advance_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_q) || cnt_q == '0));
endmodule

// File: rtl/gpio_dbnc_filter.sv
// Module: gpio_dbnc_filter (top)
// Debounce filter for one input pin. The period is 2^n ticks of an external
// 1 ms pulse. When disabled, the raw level passes straight through.
// Assumes: raw_in is already synchronized to clk; tick_ms is one cycle wide.
module gpio_dbnc_filter
    import gpio_dbnc_pkg::*;
#(
    parameter int unsigned CTRL_W   = CTRL_W_DEF,
    parameter int unsigned EN_POS   = EN_POS_DEF,
    parameter int unsigned RATE_LSB = RATE_LSB_DEF,
    parameter int unsigned RATE_W   = RATE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              raw_in,
    output logic              level_out
);
    localparam int unsigned CNT_W = 2 ** RATE_W;

    logic             filt_en;
    logic [CNT_W-1:0] last_cnt;
    logic             mismatch;
    logic             done;
    logic             filt_q;
    logic [CTRL_W-1:0] unused_ctrl_bits;

    assign unused_ctrl_bits = ctrl_word;

    gpio_dbnc_decode #(
        .CTRL_W(CTRL_W), .EN_POS(EN_POS), .RATE_LSB(RATE_LSB),
        .RATE_W(RATE_W), .CNT_W(CNT_W)
    ) decode_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .filt_en(filt_en), .last_cnt(last_cnt)
    );

    gpio_dbnc_counter #(.CNT_W(CNT_W)) counter_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .mismatch(mismatch),
        .last_cnt(last_cnt), .done(done)
    );

    // Mismatch detect and output select
    always_comb begin
        mismatch  = filt_en && (raw_in != filt_q);
        level_out = filt_en ? filt_q : raw_in;
    end

    // Filtered level: load on reset, track while disabled, commit on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= raw_in;
        end else if (!filt_en || done) begin
            filt_q <= raw_in;
        end
    end

    // R3: with the filter on, the level holds unless the period completed
    assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !done) |=> $stable(filt_q));

    // R3: completion loads the raw level seen at that edge
    assert_commit_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (filt_q == $past(raw_in)));

    // R8: while disabled, the stored level follows the pin
    assert_track_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> (filt_q == $past(raw_in)));
endmodule

// File: tb/gpio_dbnc_filter_tb.sv
module gpio_dbnc_filter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        raw_in = 1'b0;
    logic        level_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_dbnc_filter dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ctrl_word(ctrl_word),
        .raw_in(raw_in), .level_out(level_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: level_out=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    // one tick pulse, then one idle cycle; returns at a falling edge
    task automatic pulse();
        @(negedge clk); tick_ms = 1'b1;
        @(negedge clk); tick_ms = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg(input logic en, input int n);
        return (32'(en) << 8) | (32'(n & 7) << 5);
    endfunction

    task automatic do_reset(input logic lvl);
        @(negedge clk); rst_n = 1'b0; raw_in = lvl; ctrl_word = cfg(1'b1, 3);
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        logic lvl;
        // R6: reset samples the pin level, both polarities
        do_reset(1'b1);
        check(level_out, 1'b1, "R6 reset high");
        do_reset(1'b0);
        check(level_out, 1'b0, "R6 reset low");

        // R3 R5 R7: sweep every exponent, both directions, idle gaps between ticks
        for (int n = 0; n < 8; n++) begin
            ctrl_word = cfg(1'b1, n);
            for (int d = 0; d < 2; d++) begin
                lvl = level_out;
                raw_in = ~lvl;
                for (int t = 0; t < (1 << n) - 1; t++) pulse();
                idle(20); // R5: long idle stretch adds nothing
                check(level_out, lvl, n == 7 ? "R7 hold at 127" : "R3 hold before period");
                pulse();
                check(level_out, ~lvl, n == 7 ? "R7 change at 128" : "R3 change at period");
            end
        end

        // R4: glitch back restarts the count (n=2, period 4)
        ctrl_word = cfg(1'b1, 2);
        lvl = level_out;
        raw_in = ~lvl;
        pulse(); pulse(); pulse();
        raw_in = lvl; idle(1);
        raw_in = ~lvl;
        pulse(); pulse(); pulse();
        check(level_out, lvl, "R4 restart after glitch");
        pulse();
        check(level_out, ~lvl, "R4 change after full period");

        // R1: unrelated bits set, exponent 1 -> period 2
        ctrl_word = ~32'h0000_00E0 | (32'd1 << 5);
        lvl = level_out;
        raw_in = ~lvl;
        pulse();
        check(level_out, lvl, "R1 hold with stray bits");
        pulse();
        check(level_out, ~lvl, "R1 period 2 with stray bits");

        // R1 R2: enable cleared, all other bits set -> pass-through
        ctrl_word = ~32'h0000_0100;
        @(negedge clk); raw_in = 1'b1; #1;
        check(level_out, 1'b1, "R2 pass-through high");
        @(negedge clk); raw_in = 1'b0; #1;
        check(level_out, 1'b0, "R2 pass-through low");
        @(negedge clk); raw_in = 1'b1; #1;
        check(level_out, 1'b1, "R1 R2 stray bits ignored");

        // R8: enable with steady pin keeps the level
        idle(3);
        ctrl_word = cfg(1'b1, 0);
        #1;
        check(level_out, 1'b1, "R8 level at enable");
        pulse(); pulse();
        check(level_out, 1'b1, "R8 level after ticks");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule